// File: doc/BRIEF.md
# Byte-Addressed Word Memory Controller

This block lets a processor that thinks in byte addresses work against a physical memory that only moves whole words of `BYTES` bytes, where `BYTES` is a power of two. The controller splits every byte address into a word address and a byte offset by slicing bits, so it needs no divider. A byte read fetches the whole word and returns the selected byte. A byte store is carried out as a read-modify-write: the word is fetched, one lane is replaced and the full word is written back.

The processor side has a request valid/ready handshake and a one-cycle response pulse. The memory side is a plain word port with separate read and write strobes. Read data is valid in the cycle after the read strobe and stays valid until the next read. Between array operations the controller waits out a recovery interval. That interval is set separately for operations that read and operations that write, in clock cycles.

Top module: `byte_word_ctrl`

## Requirements
- R1: The word address driven on `mem_addr` is the byte address shifted right by log2(`BYTES`), and the offset is the low log2(`BYTES`) bits. With `BYTES`=4, byte 11 is word 2 offset 3, and byte 17 is word 4 offset 1.
- R2: A byte read (`req_write`=0, `req_word`=0) returns lane `off` of the stored word, zero-extended, in `rsp_rdata`. Lane k is bits 8k+7..8k.
- R3: A word read with offset 0 returns the full stored word in `rsp_rdata`.
- R4: A byte store issues exactly one read and then one write to the same word. The written word equals the fetched word with only lane `off` replaced by `req_wdata[7:0]`.
- R5: A word write with offset 0 issues exactly one write of `req_wdata` and no read.
- R6: A word access (read or write) with a nonzero offset answers with `rsp_err`=1, issues no strobe and leaves memory unchanged. All other accesses answer with `rsp_err`=0.
- R7: After a read strobe, no strobe of either kind occurs until at least `RD_GAP` cycles later.
- R8: After a write strobe, no strobe of either kind occurs until at least `WR_GAP` cycles later.
- R9: Once a request is accepted, `req_ready` stays low until its single-cycle `rsp_valid` pulse. No other request enters between the read and write phases of a byte store.
- R10: During and right after reset, `req_ready`=1, `rsp_valid`=0, and both strobes are 0.
- R11: `mem_re` and `mem_we` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_word | input | 1 | 1 = full-word access, 0 = single byte |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8*BYTES | Store data; a byte store uses bits 7..0 |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Misaligned word access |
| rsp_rdata | output | 8*BYTES | Load result |
| mem_re | output | 1 | Word read strobe |
| mem_we | output | 1 | Word write strobe |
| mem_addr | output | ADDR_W-log2(BYTES) | Word address |
| mem_wdata | output | 8*BYTES | Word written |
| mem_rdata | input | 8*BYTES | Word read, valid the cycle after `mem_re` |

## Verification
Directed requests use the byte addresses 11 and 17 for the translation, plus one load and one store on every lane. These show whether the offset bits select the right lane and whether the high bits select the right word. Word accesses at offset 0 are mixed with word accesses at offsets 1 to 3. This tells the skipped-read full write apart from the error path, which must leave the memory and the strobes untouched. A seeded random stream of all four operation kinds runs back to back against a shadow memory. It separates a correct merge from one that corrupts a neighbouring lane. It also exposes read and write recovery gaps that are confused with each other or shortened by one cycle.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_RDW  = 3'd2,
    ST_WR   = 3'd3,
    ST_RESP = 3'd4
  } bwc_state_e;
endpackage

// File: rtl/bwc_addr_split.sv
module bwc_addr_split #(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 4,
  localparam int OFF_W = $clog2(BYTES),
  localparam int WA_W  = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] byte_addr,
  output logic [WA_W-1:0]   word_addr,
  output logic [OFF_W-1:0]  offset
);
  function automatic logic [WA_W-1:0] high_part(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] low_part(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  assign word_addr = high_part(byte_addr);
  assign offset    = low_part(byte_addr);
endmodule

// File: rtl/bwc_lane.sv
module bwc_lane #(
  parameter int BYTES  = 4,
  localparam int WORD_W = 8 * BYTES,
  localparam int OFF_W  = $clog2(BYTES)
) (
  input  logic [WORD_W-1:0] word_in,
  input  logic [OFF_W-1:0]  lane,
  input  logic [7:0]        new_byte,
  output logic [7:0]        lane_byte,
  output logic [WORD_W-1:0] merged,
  output logic [WORD_W-1:0] lane_mask
);
  function automatic logic [7:0] pick(input logic [WORD_W-1:0] w,
                                      input logic [OFF_W-1:0] k);
    return w[{k, 3'b000} +: 8];
  endfunction

  function automatic logic [WORD_W-1:0] put(input logic [WORD_W-1:0] w,
                                            input logic [OFF_W-1:0] k,
                                            input logic [7:0] b);
    logic [WORD_W-1:0] r;
    r = w;
    r[{k, 3'b000} +: 8] = b;
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] mask_of(input logic [OFF_W-1:0] k);
    logic [WORD_W-1:0] m;
    m = '0;
    m[7:0] = 8'hFF;
    return m << {k, 3'b000};
  endfunction

  assign lane_byte = pick(word_in, lane);
  assign merged    = put(word_in, lane, new_byte);
  assign lane_mask = mask_of(lane);
endmodule

// File: rtl/bwc_gap_timer.sv
module bwc_gap_timer #(
  parameter int RD_GAP = 3,
  parameter int WR_GAP = 5,
  localparam int MAX_GAP = (RD_GAP > WR_GAP) ? RD_GAP : WR_GAP,
  localparam int CNT_W   = $clog2(MAX_GAP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_go,
  input  logic wr_go,
  output logic clear
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (rd_go)       cnt <= CNT_W'(RD_GAP - 1);
    else if (wr_go)       cnt <= CNT_W'(WR_GAP - 1);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign clear = (cnt == '0);

  // R7: a read keeps the array closed for the following RD_GAP-1 cycles
  assert_rd_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> (RD_GAP <= 1) || !clear);
  // R8: a write keeps the array closed for the following WR_GAP-1 cycles
  assert_wr_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> (WR_GAP <= 1) || !clear);
  // R7, R8: no operation starts while the window is open
  assert_go_when_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go || wr_go) |-> clear);
endmodule

// File: rtl/byte_word_ctrl.sv
module byte_word_ctrl #(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 4,
  parameter int RD_GAP = 3,
  parameter int WR_GAP = 5,
  localparam int WORD_W = 8 * BYTES,
  localparam int OFF_W  = $clog2(BYTES),
  localparam int WA_W   = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              mem_re,
  output logic              mem_we,
  output logic [WA_W-1:0]   mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  import bwc_pkg::*;

  bwc_state_e        state;
  logic              op_write, op_word, rmw_loaded;
  logic [WA_W-1:0]   waddr_q;
  logic [OFF_W-1:0]  off_q;
  logic [WORD_W-1:0] wdata_q, wbuf, rdata_q;
  logic              err_q;

  logic [WA_W-1:0]   in_waddr;
  logic [OFF_W-1:0]  in_off;
  logic [7:0]        lane_byte;
  logic [WORD_W-1:0] lane_merged, lane_mask;
  logic              gap_clear;
  logic              accept, misaligned, rd_go, wr_go;

  bwc_addr_split #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_split (
    .byte_addr(req_addr), .word_addr(in_waddr), .offset(in_off)
  );

  bwc_lane #(.BYTES(BYTES)) u_lane (
    .word_in(mem_rdata), .lane(off_q), .new_byte(wdata_q[7:0]),
    .lane_byte(lane_byte), .merged(lane_merged), .lane_mask(lane_mask)
  );

  bwc_gap_timer #(.RD_GAP(RD_GAP), .WR_GAP(WR_GAP)) u_gap (
    .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .wr_go(wr_go), .clear(gap_clear)
  );

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign misaligned = req_word && (in_off != '0);
  assign rd_go      = (state == ST_RD) && gap_clear;
  assign wr_go      = (state == ST_WR) && gap_clear;

  assign mem_re    = rd_go;
  assign mem_we    = wr_go;
  assign mem_addr  = waddr_q;
  assign mem_wdata = wbuf;
  assign rsp_valid = (state == ST_RESP);
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      op_write   <= 1'b0;
      op_word    <= 1'b0;
      rmw_loaded <= 1'b0;
      waddr_q    <= '0;
      off_q      <= '0;
      wdata_q    <= '0;
      wbuf       <= '0;
      rdata_q    <= '0;
      err_q      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          op_write <= req_write;
          op_word  <= req_word;
          waddr_q  <= in_waddr;
          off_q    <= in_off;
          wdata_q  <= req_wdata;
          rdata_q  <= '0;
          err_q    <= misaligned;
          if (misaligned) begin
            state <= ST_RESP;
          end else if (req_write && req_word) begin
            wbuf  <= req_wdata;
            state <= ST_WR;
          end else begin
            state <= ST_RD;
          end
        end
        ST_RD: if (gap_clear) state <= ST_RDW;
        ST_RDW: begin
          if (op_write) begin
            wbuf       <= lane_merged;
            rmw_loaded <= 1'b1;
            state      <= ST_WR;
          end else begin
            rdata_q <= op_word ? mem_rdata : {{(WORD_W-8){1'b0}}, lane_byte};
            state   <= ST_RESP;
          end
        end
        ST_WR: if (gap_clear) state <= ST_RESP;
        ST_RESP: begin
          rmw_loaded <= 1'b0;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: one array operation per cycle
  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));
  // R4: a byte store writes only after its read phase has merged the word
  assert_rmw_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !op_word) |-> rmw_loaded);
  // R4: the merge leaves every other lane as fetched
  assert_merge_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RDW && op_write) |-> (((lane_merged ^ mem_rdata) & ~lane_mask) == '0));
  // R5: a full-word write never went through a read phase
  assert_full_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && op_word) |-> !rmw_loaded);
  // R6: a misaligned word access answers next cycle with an error and no strobe
  assert_misalign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && misaligned) |=> (rsp_valid && rsp_err && !mem_re && !mem_we));
  // R9: the response is a single pulse followed by readiness
  assert_resp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
endmodule

// File: tb/byte_word_ctrl_test.sv
`timescale 1ns/1ps
module byte_word_ctrl_test;
  localparam int ADDR_W = 8;
  localparam int BYTES  = 4;
  localparam int RD_GAP = 3;
  localparam int WR_GAP = 5;
  localparam int WORD_W = 32;
  localparam int NWORDS = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [WORD_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, mem_re, mem_we;
  logic [WORD_W-1:0] rsp_rdata, mem_wdata;
  logic [WORD_W-1:0] mem_rdata = '0;
  logic [5:0] mem_addr;

  always #4 clk = ~clk;

  byte_word_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES), .RD_GAP(RD_GAP), .WR_GAP(WR_GAP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_word(req_word), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .mem_re(mem_re), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [WORD_W-1:0] model [NWORDS];
  logic [WORD_W-1:0] shadow[NWORDS];
  int checks = 0, fails = 0;
  int cyc = 0, last_cyc = -1000, last_gap = 0;
  int n_re = 0, n_we = 0;
  int exp_word = 0;
  bit finished = 0;

  function automatic logic [WORD_W-1:0] init_word(int i);
    return (i * 32'h0103_0507) ^ 32'hA5C3_0F11;
  endfunction

  task automatic chk(bit ok, string req, logic [WORD_W-1:0] act, logic [WORD_W-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Memory model and strobe monitor, both on the falling edge.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (mem_re && mem_we) chk(0, "R11 both strobes", 32'd1, 32'd0);
      if (mem_re || mem_we) begin
        if (cyc - last_cyc < last_gap)
          chk(0, (last_gap == RD_GAP) ? "R7 read gap" : "R8 write gap",
              cyc - last_cyc, last_gap);
        else
          chk(1, "R7/R8 gap", 0, 0);
        chk(int'(mem_addr) == exp_word, "R1 word address", mem_addr, exp_word);
        last_cyc = cyc;
        last_gap = mem_re ? RD_GAP : WR_GAP;
      end
      if (mem_re) begin n_re++; mem_rdata <= model[mem_addr]; end
      if (mem_we) begin n_we++; model[mem_addr] = mem_wdata; end
    end
  end

  task automatic do_req(bit wr, bit wd, logic [7:0] addr, logic [WORD_W-1:0] data);
    int w, o, waits;
    bit mis, ready_leak;
    logic [WORD_W-1:0] expd, got;
    bit goterr;
    w = int'(addr) / BYTES;
    o = int'(addr) % BYTES;
    mis = wd && (o != 0);
    waits = 0;
    while (!req_ready && waits < 50) begin @(negedge clk); waits++; end
    exp_word = w;
    n_re = 0; n_we = 0;
    req_valid = 1; req_write = wr; req_word = wd; req_addr = addr; req_wdata = data;
    @(negedge clk);
    req_valid = 0;
    ready_leak = 0;
    waits = 0;
    while (!rsp_valid && waits < 100) begin
      if (req_ready) ready_leak = 1;
      @(negedge clk); waits++;
    end
    if (waits >= 100) chk(0, "R9 no response", 0, 1);
    got = rsp_rdata; goterr = rsp_err;
    chk(!ready_leak, "R9 ready held low", ready_leak, 0);
    chk(goterr == mis, "R6 error flag", goterr, mis);
    if (mis) begin
      chk(n_re == 0 && n_we == 0, "R6 no strobe", n_re + n_we, 0);
    end else if (!wr) begin
      expd = wd ? shadow[w] : ((shadow[w] >> (8 * o)) & 32'hFF);
      chk(got == expd, wd ? "R3 word read" : "R2 byte read", got, expd);
      chk(n_re == 1 && n_we == 0, "R2 read strobes", n_re * 16 + n_we, 16);
    end else if (wd) begin
      shadow[w] = data;
      chk(n_re == 0 && n_we == 1, "R5 one write no read", n_re * 16 + n_we, 1);
    end else begin
      shadow[w] = (shadow[w] & ~(32'hFF << (8 * o))) | ((data & 32'hFF) << (8 * o));
      chk(n_re == 1 && n_we == 1, "R4 read then write", n_re * 16 + n_we, 17);
    end
    chk(model[w] == shadow[w], mis ? "R6 memory unchanged" : "R4 stored word", model[w], shadow[w]);
  endtask

  initial begin
    for (int i = 0; i < NWORDS; i++) begin model[i] = init_word(i); shadow[i] = init_word(i); end
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0 && !mem_re && !mem_we, "R10 in reset",
        {req_ready, rsp_valid, mem_re, mem_we}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0 && !mem_re && !mem_we, "R10 after reset",
        {req_ready, rsp_valid, mem_re, mem_we}, 4'b1000);
    // R1: byte 11 -> word 2 lane 3, byte 17 -> word 4 lane 1
    do_req(0, 0, 8'd11, '0);
    do_req(1, 0, 8'd17, 32'h0000_00C7);
    do_req(0, 0, 8'd17, '0);
    do_req(0, 1, 8'd16, '0);
    // R2/R4: every lane of one word
    for (int k = 0; k < BYTES; k++) do_req(1, 0, 8'(40 + k), 32'(8'h10 + k));
    for (int k = 0; k < BYTES; k++) do_req(0, 0, 8'(40 + k), '0);
    // R5 and R3
    do_req(1, 1, 8'd0, 32'hDEAD_BEEF);
    do_req(0, 1, 8'd0, '0);
    // R6: misaligned word accesses
    do_req(0, 1, 8'd5, '0);
    do_req(1, 1, 8'd6, 32'h1234_5678);
    do_req(1, 1, 8'd255, 32'h1111_2222);
    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      a = 8'($urandom);
      do_req(1'($urandom), ($urandom % 4) == 0, ($urandom % 3 == 0) ? {a[7:2], 2'b00} : a, $urandom);
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule